// File: doc/BRIEF.md
# Compact modified immediate expander

This block turns a 12-bit immediate field, taken from a compact instruction encoding, into a 32-bit operand value and a shifter carry-out. The two top bits of the field choose between two forms. The first form replicates the field's low byte in one of four patterns. The second form rotates an 8-bit constant that has an implied leading one.

The block takes one field per cycle, together with the current carry flag, under an input valid. One cycle later it presents the expanded value, the carry-out and a flag. The flag marks encodings whose result is unpredictable. Instruction decode and flag update happen elsewhere.

Top module: `imm_expand`

## Requirements
- R1: While rst_n is low, and after reset until the first accepted field, out_valid, out_value, out_carry and out_unpred are all zero.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low.
- R3: For in_field[11:10]=00 and in_field[9:8]=00, out_value is 0x000000XY, where XY = in_field[7:0].
- R4: For in_field[11:10]=00 and in_field[9:8]=01, out_value is 0x00XY00XY.
- R5: For in_field[11:10]=00 and in_field[9:8]=10, out_value is 0xXY00XY00.
- R6: For in_field[11:10]=00 and in_field[9:8]=11, out_value is 0xXYXYXYXY.
- R7: out_unpred is 1 only when in_field[11:10]=00, in_field[9:8] is not 00, and XY is 0x00. It is 0 in every other case, including the rotated form.
- R8: In the replication forms (in_field[11:10]=00), out_carry equals in_carry.
- R9: When in_field[11:10] is not 00, out_value is the 32-bit zero-extension of {1'b1, in_field[6:0]} rotated right by in_field[11:7].
- R10: In the rotated form, out_carry equals bit 31 of out_value, and in_carry has no effect.
- R11: In a cycle with in_valid low, out_value, out_carry and out_unpred keep their values whatever in_field and in_carry are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Field and carry are valid this cycle |
| in_field | input | 12 | Compact immediate field |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_value | output | 32 | Expanded 32-bit operand |
| out_carry | output | 1 | Shifter carry-out |
| out_unpred | output | 1 | Encoding is unpredictable |

## Verification
The block has no parameters, so the bench builds it in its only configuration. The field is 12 bits wide, so the bench applies every field value with both carry inputs. This covers all four replication patterns with zero and non-zero bytes, and every rotate amount from 8 to 31, including amount 8, the only amount that yields a carry of one. Idle cycles with changed inputs are inserted among the valid ones to show that the outputs hold.

// File: rtl/imm_expand.sv
module imm_expand (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [11:0] in_field,
  input  logic        in_carry,
  output logic        out_valid,
  output logic [31:0] out_value,
  output logic        out_carry,
  output logic        out_unpred
);
  localparam int FW = 12;
  localparam int VW = 32;

  logic [7:0]    xy;
  logic [1:0]    pat;
  logic          is_rep;
  logic [VW-1:0] rep_val;
  logic [VW-1:0] base;
  logic [2*VW-1:0] dbl;
  logic [VW-1:0] rot_val;
  logic [4:0]    amt;
  logic [VW-1:0] nxt_val;
  logic          nxt_carry;
  logic          nxt_unpred;

  assign xy     = in_field[7:0];
  assign pat    = in_field[9:8];
  assign is_rep = (in_field[FW-1:FW-2] == 2'b00);
  assign amt    = in_field[11:7];

  always_comb begin
    case (pat)
      2'b00:   rep_val = {24'h0, xy};
      2'b01:   rep_val = {8'h0, xy, 8'h0, xy};
      2'b10:   rep_val = {xy, 8'h0, xy, 8'h0};
      default: rep_val = {xy, xy, xy, xy};
    endcase
  end

  assign base    = {24'h0, 1'b1, in_field[6:0]};
  assign dbl     = {base, base} >> amt;
  assign rot_val = dbl[VW-1:0];

  assign nxt_val    = is_rep ? rep_val : rot_val;
  assign nxt_carry  = is_rep ? in_carry : rot_val[VW-1];
  assign nxt_unpred = is_rep && (pat != 2'b00) && (xy == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_value  <= '0;
      out_carry  <= 1'b0;
      out_unpred <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_value  <= nxt_val;
        out_carry  <= nxt_carry;
        out_unpred <= nxt_unpred;
      end
    end
  end
endmodule

module imm_expand_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [11:0] in_field,
  input logic        in_carry,
  input logic        out_valid,
  input logic [31:0] out_value,
  input logic        out_carry,
  input logic        out_unpred
);
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_value) && $stable(out_carry) && $stable(out_unpred)));
  assert_rot_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_field[11:10] != 2'b00) |=> !out_unpred);
  assert_rep_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_field[11:10] == 2'b00) |=> (out_carry == $past(in_carry)));
  assert_rot_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_field[11:10] != 2'b00) |=> (out_carry == out_value[31]));
  assert_rot_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_field[11:10] != 2'b00) |=> ($countones(out_value) == $countones({1'b1, $past(in_field[6:0])})));
  assert_flag_zero_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unpred) |-> (out_value == 32'h0));
endmodule

bind imm_expand imm_expand_chk chk_i (.*);

// File: tb/imm_expand_tb_top.sv
module imm_expand_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] value;
    logic        carry;
    logic        unpred;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_field = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic [31:0] out_value;
  logic        out_carry;
  logic        out_unpred;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t sb[$];
  exp_t last;
  bit   have_last = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imm_expand dut_i (.*);

  function automatic exp_t model(logic [11:0] f, logic c);
    exp_t e;
    logic [7:0]  b;
    logic [31:0] v;
    int r;
    b = f[7:0];
    e.unpred = 1'b0;
    if (f[11:10] == 2'b00) begin
      e.carry = c;
      case (f[9:8])
        2'b00: begin e.value = 32'(b); e.tag = "R3/R8"; end
        2'b01: begin e.value = (32'(b) << 16) | 32'(b); e.tag = "R4/R7/R8"; end
        2'b10: begin e.value = (32'(b) << 24) | (32'(b) << 8); e.tag = "R5/R7/R8"; end
        default: begin e.value = 32'(b) * 32'h01010101; e.tag = "R6/R7/R8"; end
      endcase
      if (f[9:8] != 2'b00 && b == 8'h00) e.unpred = 1'b1;
    end else begin
      v = 32'h80 | 32'(f[6:0]);
      r = int'(f[11:7]);
      e.value = (v >> r) | (v << (32 - r));
      e.carry = e.value[31];
      e.tag = "R9/R10/R7";
    end
    return e;
  endfunction

  task automatic drive(logic [11:0] f, logic c);
    @(negedge clk);
    in_valid = 1'b1;
    in_field = f;
    in_carry = c;
    sb.push_back(model(f, c));
  endtask

  task automatic idle(logic [11:0] f, logic c);
    @(negedge clk);
    in_valid = 1'b0;
    in_field = f;
    in_carry = c;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R2: out_valid actual 1 expected 0 (no pending item)");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (out_value !== e.value || out_carry !== e.carry || out_unpred !== e.unpred) begin
            n_fail++;
            $display("FAIL %s: value/carry/unpred actual %h/%b/%b expected %h/%b/%b",
                     e.tag, out_value, out_carry, out_unpred, e.value, e.carry, e.unpred);
          end
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        n_checks++;
        if (out_value !== last.value || out_carry !== last.carry || out_unpred !== last.unpred) begin
          n_fail++;
          $display("FAIL R11: held value/carry/unpred actual %h/%b/%b expected %h/%b/%b",
                   out_value, out_carry, out_unpred, last.value, last.carry, last.unpred);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_value !== 32'h0 || out_carry !== 1'b0 || out_unpred !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs actual %b/%h/%b/%b expected 0/00000000/0/0",
               out_valid, out_value, out_carry, out_unpred);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(12'hFFF, 1'b1);
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_value !== 32'h0 || out_carry !== 1'b0 || out_unpred !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: idle after reset actual %b/%h/%b/%b expected 0/00000000/0/0",
               out_valid, out_value, out_carry, out_unpred);
    end
    for (int c = 0; c < 2; c++) begin
      for (int f = 0; f < 4096; f++) begin
        drive(12'(f), c[0]);
        if ((f % 7) == 3) idle(~12'(f), ~c[0]);
      end
    end
    drive(12'h400, 1'b0);
    idle(12'h0FF, 1'b1);
    idle(12'h100, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: pending items actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule